// File: doc/BRIEF.md
# Decoded Memory and I/O Bus Subsystem

This block is the memory and I/O side of an 8-bit processor bus. The processor presents a 16-bit address, an 8-bit write-data bus and four active-low strobes: memory request, I/O request, read and write. The two top address bits pick one of four 16 KB regions. Region 0 is a ROM and regions 1 to 3 are RAM banks. Each region can be marked unpopulated. Read data comes back on a dedicated read bus, not on a shared tristate bus.

Each bank stores `2^STORE_AW` bytes. A parameter sets how the region bits above that size are treated. Under full decoding they must be zero, and any other address in the region behaves like an empty hole. Under partial decoding they are ignored, so the bank repeats (aliases) through its whole region.

A separate 256-port I/O space is addressed by the low address byte alone. It holds one output latch and one input port.

Top module: `bus_subsys`

## Requirements
- R1: A15:A14 select the region: 00 is the ROM, 01 is RAM1, 10 is RAM2 and 11 is RAM3. At most one bank is selected at a time. A RAM byte written on a clock edge, with memory request and write both low, reads back combinationally while memory request and read are low.
- R2: A bank is selected only while memory request is low. An I/O write whose address falls inside a RAM range leaves that RAM byte unchanged.
- R3: The ROM byte at offset k reads as the low byte of k XOR A5h. A write cycle into the ROM range leaves the ROM unchanged.
- R4: A region whose `POP_MASK` bit is 0 reads FFh. A write to it stores nothing.
- R5: With `FULL_DECODE`=1, a bank answers only where address bits 13 down to `STORE_AW` are zero. Any other address in the region reads FFh, and a write there leaves the bank unchanged.
- R6: With `FULL_DECODE`=0, address bits 13 down to `STORE_AW` are ignored. A byte written through one alias reads back through every other alias in the same region.
- R7: The output latch resets to 00h. It loads the write-data bus on a clock edge where I/O request and write are low, memory request is high, and A7:A0 equal `OUT_PORT` (03h). A15:A8 are ignored. Writes to other ports, and memory writes, leave the latch unchanged.
- R8: An I/O read with A7:A0 equal to `IN_PORT` (02h) returns `port_in`, whatever A15:A8 hold. An I/O read of any other port returns FFh. A memory read at the same low address returns memory, not `port_in`.
- R9: While read is high, or no source is selected, the read bus shows FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Address bus |
| wdata | input | 8 | Write data from the processor |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rdata | output | 8 | Read data back to the processor |
| port_in | input | 8 | External inputs of the input port |
| port_out | output | 8 | Output latch contents |

## Verification
The bench builds two copies side by side on the same bus, both with `STORE_AW`=8. The first uses full decoding with RAM1 unpopulated (`POP_MASK`=1101b), which exposes the empty-region holes and the out-of-range addresses inside a populated region. The second uses partial decoding with every region populated. This lets one write at 8A37h corrupt nothing in the first copy while it aliases onto 8037h and BF37h in the second. The same address 4010h then reads FFh in one copy and the stored byte in the other.

// File: rtl/bus_pkg.sv
// Shared constants and helpers for the decoded bus subsystem.
// Assumes an 8-bit data path and four equal regions chosen by the two top address bits.
package bus_pkg;
    localparam int DATA_W      = 8;
    localparam int NUM_REGIONS = 4;
    localparam int REGION_W    = 2;
    localparam int ROM_REGION  = 0;
    localparam logic [DATA_W-1:0] IDLE_BYTE = 8'hFF;
    localparam logic [DATA_W-1:0] ROM_MASK  = 8'hA5;

    // Fixed ROM content: low byte of the offset mixed with a constant.
    function automatic logic [DATA_W-1:0] rom_byte(input logic [DATA_W-1:0] low_ofs);
        return low_ofs ^ ROM_MASK;
    endfunction
endpackage

// File: rtl/bus_decoder.sv
// Region decoder: turns the address and the memory strobe into one-hot bank selects.
// Assumes STORE_AW <= ADDR_W-2. Full decoding demands zero upper offset bits; partial ignores them.
module bus_decoder
    import bus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int STORE_AW    = 8,
    parameter bit FULL_DECODE = 1'b1,
    parameter logic [NUM_REGIONS-1:0] POP_MASK = '1
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   mreq_n,
    input  logic                   iorq_n,
    output logic [NUM_REGIONS-1:0] sel,
    output logic [STORE_AW-1:0]    offset
);
    localparam int OFS_W = ADDR_W - REGION_W;

    logic                in_range;
    logic [REGION_W-1:0] region;

    assign region = addr[ADDR_W-1:OFS_W];
    assign offset = addr[STORE_AW-1:0];

    // Decide whether the upper offset bits take part in selection.
    generate
        if (FULL_DECODE && (STORE_AW < OFS_W)) begin : g_full
            assign in_range = (addr[OFS_W-1:STORE_AW] == '0);
        end else begin : g_partial
            assign in_range = 1'b1;
        end
    endgenerate

    // One select per region, qualified by the memory strobe and population.
    always_comb begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
            sel[r] = !mreq_n && iorq_n && (region == REGION_W'(r))
                     && POP_MASK[r] && in_range;
        end
    end
endmodule

// File: rtl/bus_ram_bank.sv
// One RAM bank of 2^STORE_AW bytes: synchronous write, combinational read.
// Assumes the caller qualifies the write enable with the bank select and write strobe.
module bus_ram_bank
    import bus_pkg::*;
#(
    parameter int STORE_AW = 8
) (
    input  logic                clk,
    input  logic                we,
    input  logic [STORE_AW-1:0] offset,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << STORE_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte on the enabled edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[offset] <= wdata;
        end
    end

    assign rdata = mem[offset];
endmodule

// File: rtl/bus_io_ports.sv
// I/O space: one output latch and one input port, addressed by the low address byte only.
// Assumes the memory strobe is high on genuine I/O cycles.
module bus_io_ports
    import bus_pkg::*;
#(
    parameter int PORT_AW = 8,
    parameter logic [PORT_AW-1:0] IN_PORT  = 8'h02,
    parameter logic [PORT_AW-1:0] OUT_PORT = 8'h03
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORT_AW-1:0] port_addr,
    input  logic               mreq_n,
    input  logic               iorq_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [DATA_W-1:0]  wdata,
    output logic               in_hit,
    output logic [DATA_W-1:0]  port_out
);
    logic io_cycle;
    logic out_load;

    assign io_cycle = !iorq_n && mreq_n;
    assign out_load = io_cycle && !wr_n && (port_addr == OUT_PORT);
    assign in_hit   = io_cycle && !rd_n && (port_addr == IN_PORT);

    // Output latch: clear on reset, load on a matching I/O write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_out <= '0;
        end else if (out_load) begin
            port_out <= wdata;
        end
    end
endmodule

// File: rtl/bus_subsys.sv
// Top of the decoded memory and I/O subsystem.
// Region 0 is ROM, regions 1..3 are RAM; unpopulated regions and misses read IDLE_BYTE.
module bus_subsys
    import bus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int STORE_AW    = 8,
    parameter bit FULL_DECODE = 1'b1,
    parameter logic [NUM_REGIONS-1:0] POP_MASK = 4'b1111,
    parameter int PORT_AW     = 8,
    parameter logic [PORT_AW-1:0] IN_PORT  = 8'h02,
    parameter logic [PORT_AW-1:0] OUT_PORT = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [7:0]        rdata,
    input  logic [7:0]        port_in,
    output logic [7:0]        port_out
);
    logic [NUM_REGIONS-1:0] bank_sel;
    logic [STORE_AW-1:0]    offset;
    logic [DATA_W-1:0]      bank_rd [NUM_REGIONS];
    logic [DATA_W-1:0]      mem_rd;
    logic                   in_hit;

    bus_decoder #(
        .ADDR_W(ADDR_W), .STORE_AW(STORE_AW),
        .FULL_DECODE(FULL_DECODE), .POP_MASK(POP_MASK)
    ) u_dec (
        .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .sel(bank_sel), .offset(offset)
    );

    // ROM in region 0, RAM banks in every other region.
    generate
        for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_bank
            if (r == ROM_REGION) begin : g_rom
                logic [DATA_W-1:0] low_ofs;
                assign low_ofs   = DATA_W'(offset);
                assign bank_rd[r] = rom_byte(low_ofs);
            end else begin : g_ram
                bus_ram_bank #(.STORE_AW(STORE_AW)) u_ram (
                    .clk(clk),
                    .we(bank_sel[r] && !wr_n),
                    .offset(offset),
                    .wdata(wdata),
                    .rdata(bank_rd[r])
                );
            end
        end
    endgenerate

    bus_io_ports #(
        .PORT_AW(PORT_AW), .IN_PORT(IN_PORT), .OUT_PORT(OUT_PORT)
    ) u_io (
        .clk(clk), .rst_n(rst_n), .port_addr(addr[PORT_AW-1:0]),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .wdata(wdata), .in_hit(in_hit), .port_out(port_out)
    );

    // AND-OR mux of the one-hot bank outputs.
    always_comb begin
        mem_rd = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            mem_rd |= bank_rd[r] & {DATA_W{bank_sel[r]}};
        end
    end

    // Single driver of the read bus; idle byte when nothing answers.
    always_comb begin
        if (!rd_n && (|bank_sel)) begin
            rdata = mem_rd;
        end else if (in_hit) begin
            rdata = port_in;
        end else begin
            rdata = IDLE_BYTE;
        end
    end
endmodule

// File: rtl/bus_subsys_chk.sv
// Assertion checker for bus_subsys, attached by bind below.
// Assumes the bank-select vector of the top is visible as bank_sel.
module bus_subsys_chk
    import bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [NUM_REGIONS-1:0] POP_MASK = 4'b1111,
    parameter logic [7:0] IN_PORT  = 8'h02,
    parameter logic [7:0] OUT_PORT = 8'h03
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      addr,
    input logic [7:0]             wdata,
    input logic                   mreq_n,
    input logic                   iorq_n,
    input logic                   rd_n,
    input logic                   wr_n,
    input logic [7:0]             rdata,
    input logic [7:0]             port_in,
    input logic [7:0]             port_out,
    input logic [NUM_REGIONS-1:0] bank_sel
);
    logic out_wr;
    assign out_wr = !iorq_n && mreq_n && !wr_n && (addr[7:0] == OUT_PORT);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_sel)); // R1
    AST_SEL_NEEDS_MREQ: assert property (@(posedge clk) disable iff (!rst_n) (|bank_sel) |-> !mreq_n); // R2
    AST_HOLE_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && iorq_n && !rd_n && !POP_MASK[addr[ADDR_W-1 -: 2]]) |-> rdata == 8'hFF); // R4
    AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |=> port_out == $past(wdata)); // R7
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr |=> $stable(port_out)); // R7
    AST_IN_PORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && mreq_n && !rd_n && addr[7:0] == IN_PORT) |-> rdata == port_in); // R8
    AST_IDLE_FF: assert property (@(posedge clk) disable iff (!rst_n) rd_n |-> rdata == 8'hFF); // R9
endmodule

bind bus_subsys bus_subsys_chk #(
    .ADDR_W(ADDR_W), .POP_MASK(POP_MASK), .IN_PORT(IN_PORT), .OUT_PORT(OUT_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata),
    .port_in(port_in), .port_out(port_out), .bank_sel(bank_sel)
);

// File: tb/tb_bus_subsys.sv
// Directed bench: one fully decoded copy (RAM1 empty) and one partially decoded copy on one bus.
module tb_bus_subsys;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  port_in = 8'h00;
    logic [7:0]  rdata_f, rdata_p, pout_f, pout_p;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    bus_subsys #(.STORE_AW(8), .FULL_DECODE(1'b1), .POP_MASK(4'b1101)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mreq_n(mreq_n),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata_f),
        .port_in(port_in), .port_out(pout_f)
    );

    bus_subsys #(.STORE_AW(8), .FULL_DECODE(1'b0), .POP_MASK(4'b1111)) dut_p (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mreq_n(mreq_n),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata_p),
        .port_in(port_in), .port_out(pout_p)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Bus cycle helpers: drive after a falling edge, sample before the rising edge.
    task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; mreq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); mreq_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; iorq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); iorq_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic mem_rd(input logic [15:0] a, output logic [7:0] df, output logic [7:0] dp);
        @(negedge clk); addr = a; mreq_n = 1'b0; rd_n = 1'b0;
        #2; df = rdata_f; dp = rdata_p;
        @(negedge clk); mreq_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic io_rd(input logic [15:0] a, output logic [7:0] df);
        @(negedge clk); addr = a; iorq_n = 1'b0; rd_n = 1'b0;
        #2; df = rdata_f;
        @(negedge clk); iorq_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk); #2;
        check("R7 reset latch", pout_f, 8'h00);
        check("R9 idle full", rdata_f, 8'hFF);
        check("R9 idle partial", rdata_p, 8'hFF);
    endtask

    task automatic t_regions;
        logic [7:0] f, p;
        mem_wr(16'hC0F0, 8'h3C);
        mem_wr(16'h80F0, 8'hC3);
        mem_wr(16'h4020, 8'h66);
        mem_rd(16'hC0F0, f, p); check("R1 RAM3 full", f, 8'h3C); check("R1 RAM3 partial", p, 8'h3C);
        mem_rd(16'h80F0, f, p); check("R1 RAM2 full", f, 8'hC3); check("R1 RAM2 partial", p, 8'hC3);
        mem_rd(16'h4020, f, p); check("R1 RAM1 partial", p, 8'h66);
        check("R4 RAM1 empty reads FF", f, 8'hFF);
        @(negedge clk); addr = 16'hC0F0; mreq_n = 1'b0; #2;
        check("R9 no read strobe", rdata_f, 8'hFF);
        mreq_n = 1'b1;
    endtask

    task automatic t_rom_hole;
        logic [7:0] f, p;
        mem_rd(16'h0034, f, p); check("R3 ROM 0034", f, 8'h91);
        mem_wr(16'h0005, 8'h00);
        mem_rd(16'h0005, f, p); check("R3 ROM write ignored", f, 8'hA0);
        mem_wr(16'h4010, 8'h5A);
        mem_rd(16'h4010, f, p);
        check("R4 empty write dropped", f, 8'hFF);
        check("R4 populated copy stores", p, 8'h5A);
    endtask

    task automatic t_full_partial;
        logic [7:0] f, p;
        mem_wr(16'h8037, 8'h11);
        mem_wr(16'h8A37, 8'hEE);
        mem_rd(16'h8037, f, p);
        check("R5 base not corrupted", f, 8'h11);
        check("R6 alias write lands", p, 8'hEE);
        mem_rd(16'h8A37, f, p); check("R5 out of range FF", f, 8'hFF);
        mem_rd(16'hBF37, f, p); check("R6 alias BF37", p, 8'hEE);
        mem_rd(16'h1234, f, p);
        check("R5 ROM out of range", f, 8'hFF);
        check("R6 ROM alias", p, 8'h91);
    endtask

    task automatic t_io;
        logic [7:0] f, p;
        io_wr(16'hC0F0, 8'h77);
        mem_rd(16'hC0F0, f, p); check("R2 io write spares RAM", f, 8'h3C);
        check("R7 other port ignored", pout_f, 8'h00);
        io_wr(16'h0003, 8'hA9); #2; check("R7 latch load", pout_f, 8'hA9);
        io_wr(16'h1203, 8'h5C); #2; check("R7 upper bits ignored", pout_f, 8'h5C);
        io_wr(16'h0004, 8'h11); #2; check("R7 port 04 ignored", pout_f, 8'h5C);
        mem_wr(16'h0003, 8'h22); #2; check("R7 memory write ignored", pout_f, 8'h5C);
        port_in = 8'h6B;
        io_rd(16'h0002, f); check("R8 input port", f, 8'h6B);
        io_rd(16'hFF02, f); check("R8 upper bits ignored", f, 8'h6B);
        io_rd(16'h0003, f); check("R8 unmapped port FF", f, 8'hFF);
        io_rd(16'h80F0, f); check("R2 io read not memory", f, 8'hFF);
        mem_rd(16'h0002, f, p); check("R8 memory read not port", f, 8'hA7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regions();
        t_rom_hole();
        t_full_partial();
        t_io();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule